// File: doc/BRIEF.md
# Shadowed dual-edge PWM channel

This block produces one pulse-width-modulated output. A two-stage prescaler divides the system clock into time quanta. An 8-bit counter steps through one PWM period, one step per quantum. The output is active over a window set by two compare points, a turn-on point and a turn-off point. When the turn-on point is larger than the turn-off point, the window wraps around the period boundary.

Software-style writes set up the channel through a two-word interface. One word holds the divider fields and the control bits. The other holds the period length and the two compare points.

Timing writes are held in a staging copy. That copy moves into the active copy only at the end of a period, so a period never mixes old and new settings. A control bit can turn this staging off. The block drives a pin level and an output enable. The output enable supports open-drain pads. A two-bit status view mirrors both.

Top module: `pwm_channel`

## Requirements
- R1: After reset, every register is cleared: the channel is stopped and not enabled, `pin_o` is 0, `pin_oe` is 1 and `status_o` is 2'b10.
- R2: A write with `wr_sel`=0 loads the control word: [7:0] low divider L, [11:8] shift S, [12] pin enable, [13] clock enable, [14] invert, [15] open-drain, [16] staging off. A write with `wr_sel`=1 loads the timing word: [7:0] period P, [15:8] turn-on point A, [23:16] turn-off point B. One quantum lasts (L+1)<<S clocks, and one period lasts P+1 quanta.
- R3: When A < B, the output is active while the count c satisfies A <= c < B.
- R4: When A == B, the output is active for the whole period.
- R5: When A > B, the output is active while c >= A or c < B.
- R6: While clock enable is 0, the count and the prescaler are held at zero and the output is inactive. Clearing clock enable takes effect on the next cycle, without finishing the period. Timing written while stopped applies from the first quantum after restart.
- R7: While pin enable is 0, the pin sits at the inactive level.
- R8: The inactive level is 0, or 1 when invert is set. A change of invert flips `pin_o` in the cycle after the write, without waiting for a period boundary.
- R9: When staging is on and the channel runs, a timing write takes effect at the start of the next period.
- R10: When staging is off, a timing write takes effect in the cycle after the write.
- R11: With open-drain set, `pin_oe` is 1 only while `pin_o` is 0. Without open-drain, `pin_oe` is always 1.
- R12: `status_o` equals {`pin_oe`, `pin_o`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the timing word |
| wr_data | input | 24 | Write data |
| pin_o | output | 1 | Pin level |
| pin_oe | output | 1 | Pin drive enable |
| status_o | output | 2 | Mirror of {pin_oe, pin_o} |

## Verification
The checker watches these rules on every cycle:
- the inactive level whenever the channel is stopped or the pin is disabled;
- the full-period level when the two compare points are equal;
- the drive-enable rule in both pad modes and the status mirror;
- a zero count on the cycle after a stop;
- an active timing copy that does not move mid-period while staging is on.

Some behaviour only the directed scenarios can show, because it depends on how many cycles the output is high within a window:
- the quantum length set by the two divider fields;
- the active-cycle counts of the plain, wrapped and full windows;
- the exact cycle in which a timing write lands, with staging on versus off;
- the restart of the count at zero after a stop.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  parameter int CNT_W = 8;   // period counter and compare points
  parameter int DL_W  = 8;   // linear divider field
  parameter int DH_W  = 4;   // shift divider field
  localparam int PRE_W = DL_W + (1 << DH_W) - 1;

  typedef struct packed {
    logic            sync_off;
    logic            od;
    logic            inv;
    logic            clk_en;
    logic            pin_en;
    logic [DH_W-1:0] div_h;
    logic [DL_W-1:0] div_l;
  } ctl_t;

  typedef struct packed {
    logic [CNT_W-1:0] fall;
    logic [CNT_W-1:0] rise;
    logic [CNT_W-1:0] period;
  } tm_t;

  localparam int CTL_W = $bits(ctl_t);
  localparam int TM_W  = $bits(tm_t);
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DL_W-1:0] div_l,
  input  logic [DH_W-1:0] div_h,
  output logic            tick_o
);
  logic [PRE_W-1:0] pre_q, pre_d, limit;

  always_comb begin
    limit  = (PRE_W'(div_l) + PRE_W'(1)) << div_h;
    limit  = limit - PRE_W'(1);
    // >= so that a smaller divider written mid-quantum never overruns
    tick_o = run && (pre_q >= limit);
    if (!run || tick_o) pre_d = '0;
    else                pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/pwm_duty_counter.sv
module pwm_duty_counter
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             sync_off,
  input  tm_t              tm_stage,
  output tm_t              act_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             win_o
);
  tm_t              act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             load;

  always_comb begin
    wrap_o = tick && (cnt_q >= act_q.period);
    if (!run)        cnt_d = '0;
    else if (wrap_o) cnt_d = '0;
    else if (tick)   cnt_d = cnt_q + CNT_W'(1);
    else             cnt_d = cnt_q;

    load  = sync_off || !run || wrap_o;
    act_d = load ? tm_stage : act_q;
  end

  always_comb begin
    if (act_q.rise == act_q.fall)     win_o = 1'b1;
    else if (act_q.rise < act_q.fall) win_o = (cnt_q >= act_q.rise) && (cnt_q < act_q.fall);
    else                              win_o = (cnt_q >= act_q.rise) || (cnt_q < act_q.fall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign act_o = act_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage (
  input  logic win,
  input  logic run,
  input  logic pin_en,
  input  logic inv,
  input  logic od,
  output logic pin_o,
  output logic pin_oe
);
  logic active;

  always_comb begin
    active = win && run && pin_en;
    pin_o  = active ^ inv;
    pin_oe = od ? !pin_o : 1'b1;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [TM_W-1:0] wr_data,
  output logic            pin_o,
  output logic            pin_oe,
  output logic [1:0]      status_o
);
  logic             rst_sync_n;
  ctl_t             ctl_q, ctl_d;
  tm_t              tm_q, tm_d;
  tm_t              act;
  logic [CNT_W-1:0] cnt;
  logic             tick, wrap, win;
  logic             unused_hi;

  assign unused_hi = ^wr_data[TM_W-1:CTL_W];

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    ctl_d = ctl_q;
    tm_d  = tm_q;
    if (wr_en && !wr_sel) ctl_d = ctl_t'(wr_data[CTL_W-1:0]);
    if (wr_en &&  wr_sel) tm_d  = tm_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_q <= '0;
      tm_q  <= '0;
    end else begin
      ctl_q <= ctl_d;
      tm_q  <= tm_d;
    end
  end

  pwm_prescaler u_pre (
    .clk(clk), .rst_n(rst_sync_n), .run(ctl_q.clk_en),
    .div_l(ctl_q.div_l), .div_h(ctl_q.div_h), .tick_o(tick)
  );

  pwm_duty_counter u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .run(ctl_q.clk_en), .tick(tick),
    .sync_off(ctl_q.sync_off), .tm_stage(tm_d), .act_o(act),
    .cnt_o(cnt), .wrap_o(wrap), .win_o(win)
  );

  pwm_out_stage u_out (
    .win(win), .run(ctl_q.clk_en), .pin_en(ctl_q.pin_en), .inv(ctl_q.inv),
    .od(ctl_q.od), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  assign status_o = {pin_oe, pin_o};
endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk
  import pwm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input ctl_t             ctl,
  input tm_t              act,
  input logic [CNT_W-1:0] cnt,
  input logic             wrap,
  input logic             pin_o,
  input logic             pin_oe,
  input logic [1:0]       status_o
);
  a_r6_r7_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.clk_en || !ctl.pin_en) |-> (pin_o == ctl.inv));

  a_r4_full_window: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.clk_en && ctl.pin_en && act.rise == act.fall) |-> (pin_o != ctl.inv));

  a_r6_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.clk_en |=> (cnt == '0));

  a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.clk_en && !ctl.sync_off && !wrap) |=> $stable(act));

  a_r11_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.od |-> (pin_oe != pin_o));

  a_r11_push_pull: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.od |-> pin_oe);

  a_r12_status: assert property (@(posedge clk) disable iff (!rst_n)
    status_o == {pin_oe, pin_o});
endmodule

bind pwm_channel pwm_channel_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .ctl(ctl_q), .act(act), .cnt(cnt),
  .wrap(wrap), .pin_o(pin_o), .pin_oe(pin_oe), .status_o(status_o)
);

// File: tb/sim_pwm_channel.sv
module sim_pwm_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [23:0] wr_data = '0;
  logic        pin_o, pin_oe;
  logic [1:0]  status_o;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  pwm_channel u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pin_o(pin_o), .pin_oe(pin_oe), .status_o(status_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] ctlw(int dl, int dh, bit pe, bit ce, bit iv, bit od, bit so);
    return {7'd0, so, od, iv, ce, pe, 4'(dh), 8'(dl)};
  endfunction

  function automatic logic [23:0] tmw(int p, int a, int b);
    return {8'(b), 8'(a), 8'(p)};
  endfunction

  // called at a negedge, returns at the next negedge with the write applied
  task automatic wr(input bit sel, input logic [23:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic high_count(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      h += int'(pin_o);
      @(negedge clk);
    end
  endtask

  // stop, load timing, restart: returns at the first sample with count 0
  task automatic setup(int p, int a, int b, int dl, int dh, bit iv, bit od, bit so);
    wr(0, ctlw(dl, dh, 1, 0, iv, od, so));
    wr(1, tmw(p, a, b));
    wr(0, ctlw(dl, dh, 1, 1, iv, od, so));
  endtask

  task automatic t_reset();
    check("R1 pin_o", int'(pin_o), 0);
    check("R1 pin_oe", int'(pin_oe), 1);
    check("R1 status", int'(status_o), 2);
  endtask

  task automatic t_windows();
    int h;
    setup(9, 0, 3, 0, 0, 0, 0, 0);
    high_count(10, h); check("R3 plain window", h, 3);
    setup(9, 4, 4, 0, 0, 0, 0, 0);
    high_count(10, h); check("R4 equal points", h, 10);
    setup(9, 7, 2, 0, 0, 0, 0, 0);
    high_count(10, h); check("R5 wrapped window", h, 5);
  endtask

  task automatic t_prescale();
    int h;
    setup(3, 0, 1, 1, 1, 0, 0, 0);   // quantum 4 clocks, period 16 clocks
    high_count(16, h); check("R2 high clocks per period", h, 4);
    check("R2 next period starts", int'(pin_o), 1);
  endtask

  task automatic t_stop_restart();
    int h;
    wr(0, ctlw(0, 0, 1, 0, 0, 0, 0));
    check("R6 stopped inactive", int'(pin_o), 0);
    wr(1, tmw(9, 0, 5));
    wr(0, ctlw(0, 0, 1, 1, 0, 0, 0));
    high_count(5, h); check("R6 restart from zero with new timing", h, 5);
    check("R6 turn-off at 5", int'(pin_o), 0);
    setup(9, 0, 5, 0, 0, 0, 0, 0);
    @(negedge clk);
    wr(0, ctlw(0, 0, 1, 0, 0, 0, 0));  // stop at count 1
    check("R6 stop mid-period", int'(pin_o), 0);
  endtask

  task automatic t_pin_inv();
    int h;
    setup(9, 0, 3, 0, 0, 0, 0, 0);
    wr(0, ctlw(0, 0, 0, 1, 0, 0, 0));
    high_count(10, h); check("R7 pin disabled", h, 0);
    wr(0, ctlw(0, 0, 0, 1, 1, 0, 0));
    high_count(10, h); check("R7 pin disabled inverted", h, 10);
    setup(9, 0, 3, 0, 0, 1, 0, 0);
    high_count(10, h); check("R8 inverted window", h, 7);
    setup(9, 2, 2, 0, 0, 0, 0, 0);
    check("R8 before flip", int'(pin_o), 1);
    wr(0, ctlw(0, 0, 1, 1, 1, 0, 0));
    check("R8 flips at once", int'(pin_o), 0);
  endtask

  task automatic t_shadow(bit so, int exp, string req);
    int h;
    setup(9, 0, 3, 0, 0, 0, 0, so);
    repeat (4) @(negedge clk);         // count 4
    wr(1, tmw(9, 0, 8));               // lands while count is 5
    high_count(10, h); check(req, h, exp);
  endtask

  task automatic t_open_drain();
    setup(9, 1, 1, 0, 0, 0, 1, 0);
    check("R11 od high released", int'(pin_oe), 0);
    check("R12 status high", int'(status_o), 1);
    wr(0, ctlw(0, 0, 0, 1, 0, 1, 0));
    check("R11 od low driven", int'(pin_oe), 1);
    check("R12 status low", int'(status_o), 2);
    wr(0, ctlw(0, 0, 1, 1, 0, 0, 0));
    check("R11 push-pull high", int'(pin_oe), 1);
    check("R12 status push-pull", int'(status_o), 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_windows();
    t_prescale();
    t_stop_restart();
    t_pin_inv();
    t_shadow(1'b0, 5, "R9 staged write waits for period end");
    t_shadow(1'b1, 8, "R10 unstaged write applies at once");
    t_open_drain();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule